// File: doc/BRIEF.md
# Converter Serial Result Port

This block is a synthesizable model of the digital serial side of a 16-bit delta-sigma converter. It cycles through three states: conversion, sleep and data output. While it converts, a cycle counter times the conversion. When the count runs out, the block latches the word on its parallel result input and makes that word ready to read as two's-complement data, most significant bit first, on a single serial data line. All activity on the serial clock and chip-select inputs is sampled in the system clock domain through two-flop synchronizers.

The serial clock level at the end of a conversion selects the read mode. A high level (idle-high clock) sends the block to sleep, and it pulls the data line low to signal that a result is ready. The first falling clock edge puts D15 on the line, each later falling edge moves on one bit, and the seventeenth falling edge starts the next conversion. A low level (idle-low clock) skips sleep. D15 appears at once, each falling edge moves on one bit, and the sixteenth falling edge starts the next conversion. A rise of chip select during data output abandons the read and starts a new conversion. With chip select tied low for two-wire use, no abort can occur.

The result word is sampled, not streamed, so the port has no valid/ready handshake and applies no back-pressure. The source must hold the word steady around the end of each conversion.

Top module: `adc_serial_port`

## Requirements
- R1: After reset the block is converting, `sdo` is high, and `sdo_oe` follows the synchronized inverse of `cs_n`.
- R2: A conversion lasts exactly CONV_CYCLES system clock cycles from entry. `sdo` stays high throughout, whatever the clock mode.
- R3: Serial clock edges that arrive during a conversion have no effect: neither the conversion length nor `sdo` changes.
- R4: If the synchronized serial clock is high when a conversion ends, the block enters sleep and drives `sdo` low as a ready flag.
- R5: In idle-high mode, the first falling edge with chip select low shows D15. Each later falling edge shows the next lower bit, down to D0. The seventeenth falling edge starts a new conversion. `sdo` changes only on falling edges during data output.
- R6: If the synchronized serial clock is low when a conversion ends, the block goes straight to data output with D15 on `sdo`, and no sleep flag appears.
- R7: In idle-low mode, each falling edge with chip select low moves `sdo` to the next lower bit. The sixteenth falling edge starts a new conversion.
- R8: The result word is captured from `result_i` in the cycle the conversion ends. Later changes on `result_i` do not alter the bits shifted out.
- R9: A rising edge of `cs_n` during data output discards the unread bits and starts a new conversion at once.
- R10: While `cs_n` is high, `sdo_oe` is low and serial clock edges do not advance the output bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host, asynchronous |
| cs_n | input | 1 | Active-low chip select, asynchronous |
| result_i | input | DATA_W | Conversion result, captured when a conversion ends |
| sdo | output | 1 | Serial data / ready flag |
| sdo_oe | output | 1 | Output enable for `sdo`, high while chip select is low |

## Verification
The idle-high read uses a result word with alternating bit groups and a change on `result_i` during the read. This separates correct MSB-first shifting and capture at conversion end from a live pass-through. The idle-low read uses a word with D15 low and D14 high, so an output that wrongly passed through sleep shows a one-bit offset. Its D0 is low, so a seventeenth-edge restart can be told from a sixteenth-edge restart. Clock pulses during a conversion, a chip-select rise after only D15, and pulses while chip select is high show the difference between state that was ignored and state that moved.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;

  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_DOUT  = 2'd2
  } port_state_e;

endpackage

// File: rtl/adc_edge_sync.sv
// Multi-stage synchronizer with edge detection on the synchronized level.
module adc_edge_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign level = chain_q[STAGES-1];
  assign rise  = chain_q[STAGES-1] & ~prev_q;
  assign fall  = ~chain_q[STAGES-1] & prev_q;

endmodule

// File: rtl/adc_conv_timer.sv
// Counts the cycles of one conversion; clears whenever not running.
module adc_conv_timer #(
  parameter int CONV_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);

  localparam int CW = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

  logic [CW-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               count_q <= '0;
    else if (!run || done)    count_q <= '0;
    else                      count_q <= count_q + 1'b1;
  end

  assign done = run && (count_q == LAST);

endmodule

// File: rtl/adc_shift_out.sv
// Holds the captured word and steps through it MSB first.
module adc_shift_out #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] word,
  input  logic              shift,
  output logic              msb,
  output logic              last
);

  localparam int IW = $clog2(DATA_W);
  localparam logic [IW-1:0] LAST_IDX = IW'(DATA_W - 1);

  logic [DATA_W-1:0] shreg_q;
  logic [IW-1:0]     idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      idx_q   <= '0;
    end else if (load) begin
      shreg_q <= word;
      idx_q   <= '0;
    end else if (shift) begin
      shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
      idx_q   <= idx_q + 1'b1;
    end
  end

  assign msb  = shreg_q[DATA_W-1];
  assign last = (idx_q == LAST_IDX);

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_port_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic [DATA_W-1:0] result_i,
  output logic              sdo,
  output logic              sdo_oe
);

  logic        sck_level, sck_rise, sck_fall;
  logic        cs_level, cs_rise, cs_fall;
  logic        cs_low;
  logic        conv_done;
  logic        load_word, shift_bit;
  logic        out_msb, last_bit;
  logic        pol_high_q;
  port_state_e state_q, state_d;

  adc_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sck_sync (
    .clk(clk), .rst_n(rst_n), .din(sck),
    .level(sck_level), .rise(sck_rise), .fall(sck_fall)
  );

  adc_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_cs_sync (
    .clk(clk), .rst_n(rst_n), .din(cs_n),
    .level(cs_level), .rise(cs_rise), .fall(cs_fall)
  );

  assign cs_low = ~cs_level;

  adc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) i_timer (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_CONV), .done(conv_done)
  );

  adc_shift_out #(.DATA_W(DATA_W)) i_shift (
    .clk(clk), .rst_n(rst_n), .load(load_word), .word(result_i),
    .shift(shift_bit), .msb(out_msb), .last(last_bit)
  );

  always_comb begin
    state_d   = state_q;
    load_word = 1'b0;
    shift_bit = 1'b0;
    unique case (state_q)
      ST_CONV: begin
        if (conv_done) begin
          load_word = 1'b1;
          state_d   = sck_level ? ST_SLEEP : ST_DOUT;
        end
      end
      ST_SLEEP: begin
        if (sck_fall && cs_low) state_d = ST_DOUT;
      end
      ST_DOUT: begin
        if (cs_rise) begin
          state_d = ST_CONV;
        end else if (sck_fall && cs_low) begin
          if (last_bit) state_d = ST_CONV;
          else          shift_bit = 1'b1;
        end
      end
      default: state_d = ST_CONV;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_CONV;
      pol_high_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_CONV && conv_done) pol_high_q <= sck_level;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_SLEEP: sdo = 1'b0;
      ST_DOUT:  sdo = out_msb;
      default:  sdo = 1'b1;
    endcase
  end

  assign sdo_oe = cs_low;

  logic unused_edges;
  assign unused_edges = sck_rise ^ cs_fall;

endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk
  import adc_port_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input port_state_e state,
  input logic        conv_done,
  input logic        pol_high,
  input logic        sck_fall,
  input logic        cs_rise,
  input logic        cs_low,
  input logic        last_bit,
  input logic        sdo
);

  // R2: conversion persists until the timer completes
  a_r2_convert_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CONV && !conv_done) |=> (state == ST_CONV));

  // R2: timer completion always leaves conversion
  a_r2_convert_exits: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CONV && conv_done) |=> (state != ST_CONV));

  // R4: sleep is only reached with an idle-high clock
  a_r4_sleep_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP) |-> pol_high);

  // R5: data line only moves on a falling edge or an abort
  a_r5_sdo_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DOUT && !sck_fall && !cs_rise) |=> $stable(sdo));

  // R7: the falling edge after the last bit restarts conversion
  a_r7_last_fall_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DOUT && sck_fall && cs_low && last_bit) |=> (state == ST_CONV));

  // R9: a chip-select rise aborts the read
  a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DOUT && cs_rise) |=> (state == ST_CONV));

endmodule

bind adc_serial_port adc_serial_port_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .state    (state_q),
  .conv_done(conv_done),
  .pol_high (pol_high_q),
  .sck_fall (sck_fall),
  .cs_rise  (cs_rise),
  .cs_low   (cs_low),
  .last_bit (last_bit),
  .sdo      (sdo)
);

// File: tb/test_adc_serial_port.sv
module test_adc_serial_port;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 16;
  localparam int CONV       = 120;
  localparam int SETTLE     = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sck = 1'b1;
  logic              cs_n = 1'b1;
  logic [DATA_W-1:0] result_i = 16'hA5C3;
  logic              sdo, sdo_oe;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_serial_port #(.DATA_W(DATA_W), .CONV_CYCLES(CONV)) i_adc_serial_port (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
    .result_i(result_i), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive_sck(input logic v);
    sck = v;
    wait_clk(SETTLE);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; sck = 1'b1; cs_n = 1'b1;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);
    check("R1 sdo after reset", 16'(sdo), 16'h1);
    check("R1 sdo_oe with cs high", 16'(sdo_oe), 16'h0);
    cs_n = 1'b0;
  endtask

  task automatic t_idle_high_read();
    logic [15:0] w;
    w = 16'hA5C3;
    wait_clk(CONV + 10);
    check("R4 ready flag low", 16'(sdo), 16'h0);
    check("R10 sdo_oe with cs low", 16'(sdo_oe), 16'h1);
    result_i = 16'h1234;  // R8: change after capture
    for (int k = 0; k < 16; k++) begin
      drive_sck(1'b0);
      check($sformatf("R5 R8 idle-high bit %0d", 15 - k), 16'(sdo), 16'(w[15-k]));
      drive_sck(1'b1);
      check($sformatf("R5 steady on rise bit %0d", 15 - k), 16'(sdo), 16'(w[15-k]));
    end
    drive_sck(1'b0);
    check("R5 17th fall restarts conversion", 16'(sdo), 16'h1);
  endtask

  task automatic t_convert_ignores_sck();
    drive_sck(1'b1);
    for (int k = 0; k < 3; k++) begin
      drive_sck(1'b0);
      drive_sck(1'b1);
    end
    check("R3 sck pulses in conversion", 16'(sdo), 16'h1);
    wait_clk(CONV - 55);
    check("R2 still converting before end", 16'(sdo), 16'h1);
    wait_clk(20);
    check("R2 R4 conversion ended into sleep", 16'(sdo), 16'h0);
  endtask

  task automatic t_abort();
    drive_sck(1'b0);
    check("R8 captured D15 of new word", 16'(sdo), 16'h0);
    result_i = 16'h5A3C;
    cs_n = 1'b1;
    wait_clk(SETTLE);
    check("R9 abort returns to conversion", 16'(sdo), 16'h1);
    check("R10 sdo_oe low after cs rise", 16'(sdo_oe), 16'h0);
    cs_n = 1'b0;
  endtask

  task automatic t_idle_low_read();
    logic [15:0] w;
    w = 16'h5A3C;
    wait_clk(CONV - 16);
    check("R9 restarted conversion running", 16'(sdo), 16'h1);
    wait_clk(20);
    check("R6 D15 shown without sleep", 16'(sdo), 16'(w[15]));
    for (int k = 0; k < 15; k++) begin
      drive_sck(1'b1);
      drive_sck(1'b0);
      check($sformatf("R6 R7 idle-low bit %0d", 14 - k), 16'(sdo), 16'(w[14-k]));
    end
    drive_sck(1'b1);
    check("R7 D0 held through rise", 16'(sdo), 16'(w[0]));
    drive_sck(1'b0);
    check("R7 16th fall restarts conversion", 16'(sdo), 16'h1);
  endtask

  task automatic t_cs_high_ignore();
    cs_n = 1'b1;
    result_i = 16'h8001;
    wait_clk(CONV + 10);
    check("R10 D15 ready with cs high", 16'(sdo), 16'h1);
    check("R10 sdo_oe low", 16'(sdo_oe), 16'h0);
    for (int k = 0; k < 3; k++) begin
      drive_sck(1'b1);
      drive_sck(1'b0);
    end
    check("R10 pulses with cs high ignored", 16'(sdo), 16'h1);
    cs_n = 1'b0;
    wait_clk(SETTLE);
    check("R10 sdo_oe high after cs low", 16'(sdo_oe), 16'h1);
    check("R10 D15 still shown", 16'(sdo), 16'h1);
    drive_sck(1'b1);
    drive_sck(1'b0);
    check("R10 first enabled fall shows D14", 16'(sdo), 16'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_idle_high_read();
    t_convert_ignores_sck();
    t_abort();
    t_idle_low_read();
    t_cs_high_ignore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule